// File: doc/BRIEF.md
# First-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a single first-level descriptor from memory and decoding it. A requester presents the virtual address with a valid/ready handshake, while a separate input supplies the base address of the first-level table. The walker computes where the descriptor sits in the table, issues one read on a simple memory port, waits for the returned word, and classifies it.

The result is one of four kinds. A fault means the entry translates nothing. A section maps a 1 MB region. A supersection maps a 16 MB region and yields a 40-bit physical address. A table pointer gives the base of a second-level table, which is the only thing reported for that kind. For the two mapping kinds the walker also returns the memory attribute fields. The result stays on the outputs until the requester acknowledges it.

The control is a four-state machine. IDLE accepts a request (IDLE to FETCH on `req_valid`). FETCH raises the memory request for one cycle (FETCH to WAIT, unconditional). WAIT captures the decoded descriptor when read data arrives (WAIT to RESP on `mem_rvalid`). RESP presents the result until it is acknowledged (RESP to IDLE on `rsp_ack`).

Top module: `xlat_l1_walker`

## Requirements
- R1: Each accepted request produces exactly one single-cycle `mem_req` pulse, with `mem_addr` equal to `tbl_base + vaddr[31:20]*4` (modulo 2^32).
- R2: A descriptor whose bits [1:0] are 00 or 11 yields `rsp_kind` 0 (fault), with `rsp_paddr`, `rsp_next_base` and every attribute output at zero.
- R3: A descriptor with bits [1:0] = 10 and bit 18 = 0 yields `rsp_kind` 1 (section), with `rsp_paddr` = {8'h00, desc[31:20], vaddr[19:0]}.
- R4: A descriptor with bits [1:0] = 10 and bit 18 = 1 yields `rsp_kind` 2 (supersection), with `rsp_paddr` = {desc[8:5], desc[23:20], desc[31:24], vaddr[23:0]}.
- R5: A descriptor with bits [1:0] = 01 yields `rsp_kind` 3 (table pointer), with `rsp_next_base` = desc[31:10], and `rsp_paddr` and all attributes at zero.
- R6: For sections and supersections the attributes are read as follows: `rsp_bufferable` from bit 2, `rsp_cacheable` from bit 3, `rsp_exec_never` from bit 4, `rsp_memtype` from bits [14:12], `rsp_perm` = {bit 15, bits [11:10]}, `rsp_shareable` from bit 16, `rsp_not_global` from bit 17 and `rsp_nonsecure` from bit 19. For a section, `rsp_domain` comes from bits [8:5].
- R7: For a supersection, `rsp_domain` is zero.
- R8: `req_ready` is high only in IDLE. A request offered while the walker is busy is neither accepted nor able to alter the result in progress.
- R9: Once `rsp_valid` rises, it stays high and all result outputs stay stable until a cycle with `rsp_ack` high. After that cycle the walker returns to IDLE.
- R10: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. The walker ignores `mem_rdata` in any cycle where `mem_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker is idle and can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Byte address of the first-level table |
| mem_req | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor read address |
| mem_rdata | input | 32 | Returned descriptor word |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Requester consumes the result |
| rsp_kind | output | 2 | 0 fault, 1 section, 2 supersection, 3 table pointer |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_next_base | output | 22 | Second-level table base, bits [31:10] |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_exec_never | output | 1 | Execute-never attribute |
| rsp_domain | output | 4 | Domain number (zero for supersections) |
| rsp_perm | output | 3 | Access permission, high bit first |
| rsp_memtype | output | 3 | Memory type extension field |
| rsp_shareable | output | 1 | Shareable attribute |
| rsp_not_global | output | 1 | Not-global attribute |
| rsp_nonsecure | output | 1 | Non-secure attribute |

## Verification
The hardest situation to reach is a result held in RESP while a new request is offered and stale read data still sits on the memory bus. In that state the only correct behaviour is that nothing changes. The stimulus gets there by leaving `rsp_ack` low for several cycles and, during that time, driving `req_valid` with a different address and toggling `mem_rdata` with `mem_rvalid` low. It then confirms that `req_ready` stays low, that no further read pulse appears, and that the result is unchanged after the acknowledge. Supersection address assembly is covered with descriptors whose three address fields carry distinct nibbles, so that any swap shows up in the 40-bit result.

// File: rtl/xlat_l1_pkg.sv
package xlat_l1_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 40;
    localparam int DESC_W  = 32;
    localparam int IDX_W   = 12;
    localparam int NB_W    = 22;

    // descriptor field positions the decoder depends on
    localparam int POS_B   = 2;
    localparam int POS_C   = 3;
    localparam int POS_XN  = 4;
    localparam int POS_DOM = 5;
    localparam int POS_AP  = 10;
    localparam int POS_TEX = 12;
    localparam int POS_AP2 = 15;
    localparam int POS_S   = 16;
    localparam int POS_NG  = 17;
    localparam int POS_SUP = 18;
    localparam int POS_NS  = 19;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_FAULT   = 2'd0,
        KIND_SECTION = 2'd1,
        KIND_SUPER   = 2'd2,
        KIND_TABLE   = 2'd3
    } walk_kind_e;

    typedef struct packed {
        logic       bufferable;
        logic       cacheable;
        logic       exec_never;
        logic [3:0] domain;
        logic [2:0] perm;
        logic [2:0] memtype;
        logic       shareable;
        logic       not_global;
        logic       nonsecure;
    } walk_attr_t;

    typedef struct packed {
        walk_kind_e        kind;
        logic [PA_W-1:0]   paddr;
        logic [NB_W-1:0]   next_base;
        walk_attr_t        attr;
    } walk_result_t;

endpackage

// File: rtl/xlat_l1_addr.sv
module xlat_l1_addr
    import xlat_l1_pkg::*;
#(
    parameter int AW    = VA_W,
    parameter int IW    = IDX_W
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] index,
    output logic [AW-1:0] fetch_addr
);
    localparam int WORD_SHIFT = 2;

    logic [AW-1:0] offset;

    always_comb begin
        offset     = '0;
        offset[IW+WORD_SHIFT-1:WORD_SHIFT] = index;
        fetch_addr = base + offset;
    end

endmodule

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
    import xlat_l1_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [23:0]       va_low,
    output walk_result_t      res
);
    logic is_super;
    logic unused_desc_bit;

    assign is_super        = desc[POS_SUP];
    assign unused_desc_bit = desc[9];

    always_comb begin
        res = '0;
        unique case (desc[1:0])
            2'b01: begin
                res.kind      = KIND_TABLE;
                res.next_base = desc[DESC_W-1:DESC_W-NB_W];
            end
            2'b10: begin
                res.attr.bufferable = desc[POS_B];
                res.attr.cacheable  = desc[POS_C];
                res.attr.exec_never = desc[POS_XN];
                res.attr.perm       = {desc[POS_AP2], desc[POS_AP+1:POS_AP]};
                res.attr.memtype    = desc[POS_TEX+2:POS_TEX];
                res.attr.shareable  = desc[POS_S];
                res.attr.not_global = desc[POS_NG];
                res.attr.nonsecure  = desc[POS_NS];
                if (is_super) begin
                    res.kind        = KIND_SUPER;
                    res.attr.domain = 4'h0;
                    res.paddr       = {desc[POS_DOM+3:POS_DOM], desc[23:20],
                                       desc[31:24], va_low[23:0]};
                end else begin
                    res.kind        = KIND_SECTION;
                    res.attr.domain = desc[POS_DOM+3:POS_DOM];
                    res.paddr       = {8'h00, desc[31:20], va_low[19:0]};
                end
            end
            default: begin
                res = '0;
            end
        endcase
    end

endmodule

// File: rtl/xlat_l1_fsm.sv
module xlat_l1_fsm
    import xlat_l1_pkg::*;
#(
    parameter int AW = VA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    input  logic          mem_rvalid,
    input  walk_result_t  dec_res,
    output logic          rsp_valid,
    input  logic          rsp_ack,
    output walk_result_t  rsp_res,
    output logic [AW-1:0] lat_vaddr,
    output logic [AW-1:0] lat_base
);
    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_FETCH;
            ST_FETCH:                 state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ack)    state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_vaddr <= '0;
            lat_base  <= '0;
            rsp_res   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                lat_vaddr <= req_vaddr;
                lat_base  <= tbl_base;
            end
            if (state_q == ST_WAIT && mem_rvalid) begin
                rsp_res <= dec_res;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_WAIT:  ;
            ST_RESP:  rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    // R1: a read strobe never lasts two cycles
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: walker leaves RESP only through an acknowledge
    assert_resp_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP && !rsp_ack) |=> state_q == ST_RESP);

endmodule

// File: rtl/xlat_l1_walker.sv
module xlat_l1_walker
    import xlat_l1_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] tbl_base,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    input  logic        mem_rvalid,
    output logic        rsp_valid,
    input  logic        rsp_ack,
    output logic [1:0]  rsp_kind,
    output logic [39:0] rsp_paddr,
    output logic [21:0] rsp_next_base,
    output logic        rsp_bufferable,
    output logic        rsp_cacheable,
    output logic        rsp_exec_never,
    output logic [3:0]  rsp_domain,
    output logic [2:0]  rsp_perm,
    output logic [2:0]  rsp_memtype,
    output logic        rsp_shareable,
    output logic        rsp_not_global,
    output logic        rsp_nonsecure
);
    walk_result_t dec_res;
    walk_result_t hold_res;
    logic [VA_W-1:0] lat_vaddr;
    logic [VA_W-1:0] lat_base;

    xlat_l1_fsm #(.AW(VA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .tbl_base   (tbl_base),
        .mem_req    (mem_req),
        .mem_rvalid (mem_rvalid),
        .dec_res    (dec_res),
        .rsp_valid  (rsp_valid),
        .rsp_ack    (rsp_ack),
        .rsp_res    (hold_res),
        .lat_vaddr  (lat_vaddr),
        .lat_base   (lat_base)
    );

    xlat_l1_addr #(.AW(VA_W), .IW(IDX_W)) u_addr (
        .base       (lat_base),
        .index      (lat_vaddr[VA_W-1:VA_W-IDX_W]),
        .fetch_addr (mem_addr)
    );

    xlat_l1_decode u_decode (
        .desc   (mem_rdata),
        .va_low (lat_vaddr[23:0]),
        .res    (dec_res)
    );

    assign rsp_kind       = hold_res.kind;
    assign rsp_paddr      = hold_res.paddr;
    assign rsp_next_base  = hold_res.next_base;
    assign rsp_bufferable = hold_res.attr.bufferable;
    assign rsp_cacheable  = hold_res.attr.cacheable;
    assign rsp_exec_never = hold_res.attr.exec_never;
    assign rsp_domain     = hold_res.attr.domain;
    assign rsp_perm       = hold_res.attr.perm;
    assign rsp_memtype    = hold_res.attr.memtype;
    assign rsp_shareable  = hold_res.attr.shareable;
    assign rsp_not_global = hold_res.attr.not_global;
    assign rsp_nonsecure  = hold_res.attr.nonsecure;

    // R8: the handshake never accepts while work is outstanding
    assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req));

    // R9: result is frozen while unacknowledged
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr)
                                     && $stable(rsp_kind) && $stable(rsp_next_base)));

    // R2: faults never carry an address
    assert_fault_no_pa_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd0) |-> (rsp_paddr == 40'h0 && rsp_next_base == 22'h0));

    // R3: sections stay in the low 4 GB
    assert_section_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd1) |-> rsp_paddr[39:32] == 8'h00);

    // R7: supersections report no domain
    assert_super_domain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd2) |-> rsp_domain == 4'h0);

    // R5: table pointers carry no physical address
    assert_table_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd3) |-> rsp_paddr == 40'h0);

endmodule

// File: tb/xlat_l1_walker_test.sv
module xlat_l1_walker_test;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] va;
        logic [31:0] desc;
        logic [31:0] faddr;
        logic [1:0]  kind;
        logic [39:0] pa;
        logic [21:0] nb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h12300000, 32'h00100000, 32'h00000000, 32'h12300004, 2'd0, 40'h0000000000, 22'h000000},
        '{32'h12300000, 32'hABC12345, 32'h45600002, 32'h12302AF0, 2'd1, 40'h0045612345, 22'h000000},
        '{32'h20000000, 32'h00FEDCBA, 32'h9A740182, 32'h2000003C, 2'd2, 40'hC79AFEDCBA, 22'h000000},
        '{32'h00004000, 32'hFFF00000, 32'h87654C01, 32'h00007FFC, 2'd3, 40'h0000000000, 22'h21D953},
        '{32'h40000000, 32'h80000000, 32'hFFFFFFFF, 32'h40002000, 2'd0, 40'h0000000000, 22'h000000},
        '{32'h00001000, 32'h00012345, 32'hFFFBFFFE, 32'h00001000, 2'd1, 40'h00FFF12345, 22'h000000},
        '{32'h00000000, 32'h12345678, 32'hFFFFFFFE, 32'h0000048C, 2'd2, 40'hFFFF345678, 22'h000000},
        '{32'hFFFFC000, 32'hFFF00000, 32'h00000002, 32'hFFFFFFFC, 2'd1, 40'h0000000000, 22'h000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic [1:0]  rsp_kind;
    logic [39:0] rsp_paddr;
    logic [21:0] rsp_next_base;
    logic        rsp_bufferable, rsp_cacheable, rsp_exec_never;
    logic [3:0]  rsp_domain;
    logic [2:0]  rsp_perm, rsp_memtype;
    logic        rsp_shareable, rsp_not_global, rsp_nonsecure;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    logic [31:0] seen_addr;

    always #2 clk = ~clk;

    xlat_l1_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .tbl_base(tbl_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr),
        .rsp_next_base(rsp_next_base), .rsp_bufferable(rsp_bufferable), .rsp_cacheable(rsp_cacheable),
        .rsp_exec_never(rsp_exec_never), .rsp_domain(rsp_domain), .rsp_perm(rsp_perm),
        .rsp_memtype(rsp_memtype), .rsp_shareable(rsp_shareable), .rsp_not_global(rsp_not_global),
        .rsp_nonsecure(rsp_nonsecure)
    );

    always @(negedge clk) if (rst_n && mem_req) strobes++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // issue a request, serve the descriptor after lat cycles, stop once the result is up
    task automatic walk(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] desc, input int lat);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; tbl_base = base;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'h5A5A5A5A; tbl_base = 32'hA5A5A5A5;
        guard = 0;
        while (!mem_req && guard < 50) begin @(negedge clk); guard++; end
        seen_addr = mem_addr;
        for (int k = 0; k < lat; k++) begin
            mem_rdata = 32'hDEAD0001 ^ k;   // noise with rvalid low
            @(negedge clk);
        end
        mem_rvalid = 1'b1; mem_rdata = desc;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hFFFFFFFF;
        guard = 0;
        while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    endtask

    task automatic ack();
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [39:0] pa_keep;
        logic [1:0]  kind_keep;
        int          s0;

        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", {63'h0, req_ready}, 64'h1);
        chk("R10 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        chk("R10 mem_req after reset", {63'h0, mem_req}, 64'h0);

        // table walk over all vectors
        for (int i = 0; i < NV; i++) begin
            s0 = strobes;
            walk(VECS[i].base, VECS[i].va, VECS[i].desc, (i % 3) + 1);
            chk($sformatf("R1 fetch address v%0d", i), {32'h0, seen_addr}, {32'h0, VECS[i].faddr});
            chk($sformatf("R1 one strobe v%0d", i), strobes - s0, 64'd1);
            chk($sformatf("R2 R3 R4 R5 kind v%0d", i), {62'h0, rsp_kind}, {62'h0, VECS[i].kind});
            chk($sformatf("R2 R3 R4 R5 paddr v%0d", i), {24'h0, rsp_paddr}, {24'h0, VECS[i].pa});
            chk($sformatf("R5 next base v%0d", i), {42'h0, rsp_next_base}, {42'h0, VECS[i].nb});
            if (VECS[i].kind == 2'd0 || VECS[i].kind == 2'd3)
                chk($sformatf("R2 R5 attrs zero v%0d", i),
                    {48'h0, rsp_bufferable, rsp_cacheable, rsp_exec_never, rsp_domain, rsp_perm,
                     rsp_memtype, rsp_shareable, rsp_not_global, rsp_nonsecure}, 64'h0);
            ack();
        end

        // R6: section attribute placement, one field at a time (bit 1 set marks a section)
        walk(32'h0, 32'h0, 32'h00000006, 1);   // bit 2
        chk("R6 bufferable", {61'h0, rsp_bufferable, rsp_cacheable, rsp_exec_never}, 64'h4);
        ack();
        walk(32'h0, 32'h0, 32'h00000012, 1);   // bit 4
        chk("R6 exec never", {61'h0, rsp_bufferable, rsp_cacheable, rsp_exec_never}, 64'h1);
        ack();
        walk(32'h0, 32'h0, 32'h000080A2, 1);   // bit 15, domain 5
        chk("R6 perm high", {61'h0, rsp_perm}, 64'h4);
        chk("R6 domain", {60'h0, rsp_domain}, 64'h5);
        ack();
        walk(32'h0, 32'h0, 32'h00005C0A, 1);   // bits 3, 11:10, 14:12 = 101
        chk("R6 cacheable", {63'h0, rsp_cacheable}, 64'h1);
        chk("R6 perm low", {61'h0, rsp_perm}, 64'h3);
        chk("R6 memtype", {61'h0, rsp_memtype}, 64'h5);
        ack();
        walk(32'h0, 32'h0, 32'h000A0002, 1);   // bits 17 and 19
        chk("R6 sh/ng/ns", {61'h0, rsp_shareable, rsp_not_global, rsp_nonsecure}, 64'h3);
        ack();
        walk(32'h0, 32'h0, 32'h00010002, 1);   // bit 16
        chk("R6 shareable", {61'h0, rsp_shareable, rsp_not_global, rsp_nonsecure}, 64'h4);
        ack();
        walk(32'h0, 32'h0, 32'hFFFBFFFE, 2);
        chk("R6 all section attrs",
            {48'h0, rsp_bufferable, rsp_cacheable, rsp_exec_never, rsp_domain, rsp_perm,
             rsp_memtype, rsp_shareable, rsp_not_global, rsp_nonsecure}, 64'hFFFF);
        ack();

        // R7: supersection keeps attributes but reports domain zero
        walk(32'h0, 32'h12345678, 32'hFFFFFFFE, 1);
        chk("R7 super domain", {60'h0, rsp_domain}, 64'h0);
        chk("R6 super attrs",
            {48'h0, rsp_bufferable, rsp_cacheable, rsp_exec_never, rsp_domain, rsp_perm,
             rsp_memtype, rsp_shareable, rsp_not_global, rsp_nonsecure}, 64'hE1FF);
        ack();

        // R8 R9: hold under busy traffic and noise, then acknowledge
        walk(32'h20000000, 32'h00FEDCBA, 32'h9A740182, 3);
        pa_keep = rsp_paddr; kind_keep = rsp_kind;
        s0 = strobes;
        req_valid = 1'b1; req_vaddr = 32'h00100000; tbl_base = 32'h12300000;
        for (int k = 0; k < 5; k++) begin
            mem_rdata = 32'h00000002 + (k << 20);
            @(negedge clk);
            chk("R8 not ready while busy", {63'h0, req_ready}, 64'h0);
            chk("R9 valid held", {63'h0, rsp_valid}, 64'h1);
        end
        req_valid = 1'b0;
        chk("R9 paddr held", {24'h0, rsp_paddr}, {24'h0, pa_keep});
        chk("R9 kind held", {62'h0, rsp_kind}, {62'h0, kind_keep});
        chk("R8 no strobe while busy", strobes - s0, 64'd0);
        ack();
        chk("R9 back to idle", {62'h0, req_ready, rsp_valid}, 64'h2);
        chk("R10 paddr unchanged by noise", {24'h0, rsp_paddr}, 64'h000000C79AFEDCBA);
        repeat (3) @(negedge clk);
        chk("R8 no strobe when idle", strobes - s0, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule